// File: doc/BRIEF.md
# Queue Pacer with Gap, Credit and Replay Control

This block sits between one stored packet queue and its output port and decides when each packet may leave. Packets arrive as beats under a valid/ready handshake. Each beat carries its data, a count of its valid bytes, a flag for the final beat of a packet, and a flag for the final beat of the whole stored sequence. Beats inside a packet pass through unhindered. The start of a new packet is held back until every enabled pacing condition allows it.

There are two pacing mechanisms, and each has its own enable. The first is a minimum idle spacing in clock cycles, counted from the last beat of one packet to the first beat of the next. The second is a credit counter that earns a programmed amount every cycle and spends one unit per byte sent. A global run control sits above both. A replay counter sits above that: it counts passes over the stored sequence, pulses a rewind request back to the storage after each pass, and raises a completion flag when the programmed number of passes has been sent. Each output queue of a chip gets its own instance, configured on its own, and pacing depends only on the register values and the cycle count, so every run repeats exactly.

Top module: `pkt_pacer`

## Requirements
- R1: A beat is offered downstream (`out_valid`) only while `in_valid` is high. `out_data`, `out_bytes` and `out_last` equal the input beat. `in_ready` is `out_ready` gated by the same permission as `out_valid`.
- R2: With `gap_en` high, after the cycle in which a beat with `in_last` transfers, no first beat of a packet transfers for the next `gap_cycles` cycles. A first beat may transfer in cycle `gap_cycles`+1 after it.
- R3: With `gap_en` low, a new packet may start in the cycle right after the previous packet's last beat.
- R4: With `rate_en` high, a signed credit register gains `rate_inc` every cycle and loses `in_bytes` for every beat that transfers. It saturates at CRED_CAP above and at the most negative value of its width below. A packet may start only while the credit is zero or more.
- R5: With `rate_en` low, the credit is held at zero and does not restrict packet starts.
- R6: With `run_en` low, no new packet starts. A packet already under way completes its remaining beats.
- R7: An `iter_load` pulse loads the replay count from `iter_count` and clears `done`. In the same cycle it takes priority over a decrement. Each transfer of a beat with `in_tail` high decrements a non-zero count, and it makes `rewind` high for the following cycle.
- R8: When a tail transfer brings the count from one to zero, `done` goes high in the same cycle as `rewind`. While the count is zero, including after reset, no new packet starts.
- R9: Once the first beat of a packet has transferred, later beats of that packet are never held, whatever the state of the gap, the credit, the count or `run_en`.
- R10: After reset, `out_valid`, `rewind` and `done` are low, and the gap count, the credit and the replay count are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat offered by the queue |
| in_ready | output | 1 | Beat accepted from the queue |
| in_data | input | DATA_W | Beat data |
| in_bytes | input | BYTES_W | Valid bytes in the beat |
| in_last | input | 1 | Final beat of a packet |
| in_tail | input | 1 | Final beat of the stored sequence (set together with in_last) |
| out_valid | output | 1 | Beat offered downstream |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | DATA_W | Beat data |
| out_bytes | output | BYTES_W | Valid bytes in the beat |
| out_last | output | 1 | Final beat of a packet |
| run_en | input | 1 | Global start/stop |
| gap_en | input | 1 | Enable the minimum inter-packet spacing |
| gap_cycles | input | GAP_W | Idle cycles between packets |
| rate_en | input | 1 | Enable credit-based rate control |
| rate_inc | input | INC_W | Credit earned per cycle |
| iter_count | input | ITER_W | Number of passes over the sequence |
| iter_load | input | 1 | Load the pass count and clear done |
| rewind | output | 1 | Request to restart the stored sequence |
| done | output | 1 | All programmed passes sent |

## Verification
The bench drives one-beat and multi-beat packets and stalls the downstream side. It goes after the first beat that falls exactly one cycle after the spacing expires: a counter off by one would release it a cycle early or a cycle late. It drops `run_en` in the middle of a packet, where a design that gated every beat would freeze that packet halfway. It drives short packets against a small credit increment, so the credit swings well below zero: a design that checked the credit on every beat, or forgot to charge the bytes of the last beat, would drift from the expected start cycles. It runs the replay count down to zero, where an early or missing `done`, or a packet leaking out after completion, shows up at once.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  // Reason a new packet start is being held back
  typedef enum logic [2:0] {
    HOLD_NONE = 3'd0,
    HOLD_RUN  = 3'd1,
    HOLD_ITER = 3'd2,
    HOLD_GAP  = 3'd3,
    HOLD_RATE = 3'd4
  } hold_e;
endpackage

// File: rtl/pacer_gap.sv
module pacer_gap #(
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [GAP_W-1:0] gap,
  input  logic             xfer_last,
  input  logic             start_xfer,
  output logic             clear
);
  logic [GAP_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!en)        cnt <= '0;
    else if (xfer_last)  cnt <= gap;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign clear = (cnt == '0);

  // R2
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt != '0) |-> !start_xfer);
endmodule

// File: rtl/pacer_credit.sv
module pacer_credit #(
  parameter int INC_W    = 8,
  parameter int BYTES_W  = 4,
  parameter int CRED_W   = 16,
  parameter int CRED_CAP = 1024
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [INC_W-1:0]         inc,
  input  logic                     xfer,
  input  logic [BYTES_W-1:0]       cost,
  output logic signed [CRED_W-1:0] credit,
  output logic                     ok
);
  localparam int SW = CRED_W + 2;
  localparam logic signed [SW-1:0] HI = SW'(CRED_CAP);
  localparam logic signed [SW-1:0] LO = {{3{1'b1}}, {(CRED_W-1){1'b0}}};

  function automatic logic signed [CRED_W-1:0] credit_step(
    input logic signed [CRED_W-1:0] cur,
    input logic [INC_W-1:0]         add,
    input logic [BYTES_W-1:0]       spend
  );
    logic signed [SW-1:0] s;
    s = $signed({{2{cur[CRED_W-1]}}, cur})
      + $signed({{(SW-INC_W){1'b0}}, add})
      - $signed({{(SW-BYTES_W){1'b0}}, spend});
    if (s > HI)      return HI[CRED_W-1:0];
    else if (s < LO) return LO[CRED_W-1:0];
    else             return s[CRED_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   credit <= '0;
    else if (!en) credit <= '0;
    else          credit <= credit_step(credit, inc, xfer ? cost : '0);
  end

  assign ok = !credit[CRED_W-1];

  // R4
  credit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    credit <= $signed(HI[CRED_W-1:0]));
  // R5
  credit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> credit == '0);
endmodule

// File: rtl/pacer_iter.sv
module pacer_iter #(
  parameter int ITER_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ITER_W-1:0] count,
  input  logic              tail_xfer,
  output logic              live,
  output logic              rewind,
  output logic              done
);
  logic [ITER_W-1:0] rem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem    <= '0;
      done   <= 1'b0;
      rewind <= 1'b0;
    end else begin
      rewind <= tail_xfer;
      if (load) begin
        rem  <= count;
        done <= 1'b0;
      end else if (tail_xfer && rem != '0) begin
        rem <= rem - 1'b1;
        if (rem == ITER_W'(1)) done <= 1'b1;
      end
    end
  end

  assign live = (rem != '0);

  // R8
  done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rem == '0);
  // R7
  done_with_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> rewind);
endmodule

// File: rtl/pkt_pacer.sv
module pkt_pacer
  import pacer_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int BYTES_W  = 4,
  parameter int GAP_W    = 16,
  parameter int INC_W    = 8,
  parameter int CRED_W   = 16,
  parameter int CRED_CAP = 1024,
  parameter int ITER_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [BYTES_W-1:0] in_bytes,
  input  logic               in_last,
  input  logic               in_tail,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_data,
  output logic [BYTES_W-1:0] out_bytes,
  output logic               out_last,
  input  logic               run_en,
  input  logic               gap_en,
  input  logic [GAP_W-1:0]   gap_cycles,
  input  logic               rate_en,
  input  logic [INC_W-1:0]   rate_inc,
  input  logic [ITER_W-1:0]  iter_count,
  input  logic               iter_load,
  output logic               rewind,
  output logic               done
);
  logic in_pkt, allow, xfer, start_xfer, xfer_last, tail_xfer;
  logic gap_clear, credit_ok, iter_live;
  logic signed [CRED_W-1:0] credit;
  hold_e hold_why;

  always_comb begin
    if (!run_en)                   hold_why = HOLD_RUN;
    else if (!iter_live)           hold_why = HOLD_ITER;
    else if (gap_en && !gap_clear) hold_why = HOLD_GAP;
    else if (rate_en && !credit_ok) hold_why = HOLD_RATE;
    else                           hold_why = HOLD_NONE;
  end

  assign allow      = in_pkt || (hold_why == HOLD_NONE);
  assign out_valid  = in_valid && allow;
  assign in_ready   = out_ready && allow;
  assign out_data   = in_data;
  assign out_bytes  = in_bytes;
  assign out_last   = in_last;
  assign xfer       = in_valid && in_ready;
  assign start_xfer = xfer && !in_pkt;
  assign xfer_last  = xfer && in_last;
  assign tail_xfer  = xfer && in_last && in_tail;

  always_ff @(posedge clk) begin
    if (!rst_n)    in_pkt <= 1'b0;
    else if (xfer) in_pkt <= !in_last;
  end

  pacer_gap #(.GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .en(gap_en), .gap(gap_cycles),
    .xfer_last(xfer_last), .start_xfer(start_xfer), .clear(gap_clear)
  );

  pacer_credit #(.INC_W(INC_W), .BYTES_W(BYTES_W), .CRED_W(CRED_W),
                 .CRED_CAP(CRED_CAP)) u_credit (
    .clk(clk), .rst_n(rst_n), .en(rate_en), .inc(rate_inc),
    .xfer(xfer), .cost(in_bytes), .credit(credit), .ok(credit_ok)
  );

  pacer_iter #(.ITER_W(ITER_W)) u_iter (
    .clk(clk), .rst_n(rst_n), .load(iter_load), .count(iter_count),
    .tail_xfer(tail_xfer), .live(iter_live), .rewind(rewind), .done(done)
  );

  // R1
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid);
  // R6
  run_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !in_pkt) |-> !out_valid);
  // R9
  mid_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt && in_valid) |-> out_valid);
  // R4
  credit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_en && credit < 0 && !in_pkt) |-> !out_valid);
  // R8
  done_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !iter_load && !in_pkt) |=> (!out_valid || $past(iter_load) || in_pkt));
endmodule

// File: tb/pkt_pacer_tb.sv
module pkt_pacer_tb;
  localparam int DATA_W = 64, BYTES_W = 4, GAP_W = 16, INC_W = 8;
  localparam int CRED_W = 16, CAP = 1024, ITER_W = 8;
  localparam int LO = -32768;
  localparam int NB = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, in_valid, in_ready, in_last, in_tail, out_valid, out_ready, out_last;
  logic [DATA_W-1:0] in_data, out_data;
  logic [BYTES_W-1:0] in_bytes, out_bytes;
  logic run_en, gap_en, rate_en, iter_load, rewind, done;
  logic [GAP_W-1:0] gap_cycles;
  logic [INC_W-1:0] rate_inc;
  logic [ITER_W-1:0] iter_count;

  pkt_pacer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_bytes(in_bytes), .in_last(in_last), .in_tail(in_tail),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_bytes(out_bytes), .out_last(out_last), .run_en(run_en), .gap_en(gap_en),
    .gap_cycles(gap_cycles), .rate_en(rate_en), .rate_inc(rate_inc),
    .iter_count(iter_count), .iter_load(iter_load), .rewind(rewind), .done(done)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  // stored sequence: packets of 1, 3 and 2 beats
  bit bl[NB] = '{1, 0, 0, 1, 0, 1};
  int bb[NB] = '{5, 8, 8, 7, 8, 3};

  // reference model state
  int m_credit = 0, m_gap = 0, m_rem = 0, cyc = 0, rew_seen = 0;
  bit m_inpkt = 0, m_done = 0, m_rew = 0;
  int src = 0, ctr = 0;
  bit rdy_pat = 0, bub = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic drive_src();
    in_valid   = !(bub && (cyc % 5 == 3));
    in_data    = 64'(ctr) * 64'd77 + 64'd1;
    in_bytes   = 4'(bb[src]);
    in_last    = bl[src];
    in_tail    = (src == NB - 1);
    out_ready  = !(rdy_pat && (cyc % 3 == 1));
  endtask

  // one cycle: called just after a negedge
  task automatic step();
    bit start_ok, allow, xfer, eov, eir;
    int n_credit, n_gap, n_rem;
    bit n_done;
    string why;
    drive_src();
    #1;
    start_ok = run_en && m_rem != 0 && (!gap_en || m_gap == 0) && (!rate_en || m_credit >= 0);
    allow = m_inpkt || start_ok;
    eov = in_valid && allow;
    eir = out_ready && allow;
    if (m_inpkt)                     why = "R9";
    else if (!run_en)                why = "R6";
    else if (m_rem == 0)             why = "R8";
    else if (gap_en && m_gap != 0)   why = "R2";
    else if (rate_en && m_credit < 0) why = "R4";
    else if (!rate_en)               why = "R5";
    else                             why = "R3";
    chk(out_valid == eov, why, "out_valid", out_valid, eov);
    chk(in_ready == eir, why, "in_ready", in_ready, eir);
    if (eov) begin
      chk(out_data == in_data && out_bytes == in_bytes && out_last == in_last,
          "R1", "passthrough", out_data, in_data);
    end
    xfer = in_valid && out_ready && allow;
    // next state
    if (!gap_en) n_gap = 0;
    else if (xfer && in_last) n_gap = int'(gap_cycles);
    else if (m_gap > 0) n_gap = m_gap - 1;
    else n_gap = 0;
    if (!rate_en) n_credit = 0;
    else begin
      n_credit = m_credit + int'(rate_inc) - (xfer ? int'(in_bytes) : 0);
      if (n_credit > CAP) n_credit = CAP;
      if (n_credit < LO) n_credit = LO;
    end
    n_rem = m_rem;
    n_done = m_done;
    if (iter_load) begin
      n_rem = int'(iter_count);
      n_done = 0;
    end else if (xfer && in_last && in_tail && m_rem != 0) begin
      n_rem = m_rem - 1;
      if (m_rem == 1) n_done = 1;
    end
    @(posedge clk);
    m_rew = xfer && in_last && in_tail;
    if (xfer) begin
      m_inpkt = !in_last;
      src = (src + 1) % NB;
      ctr++;
    end
    m_gap = n_gap;
    m_credit = n_credit;
    m_rem = n_rem;
    m_done = n_done;
    cyc++;
    #1;
    chk(rewind == m_rew, "R7", "rewind", rewind, m_rew);
    chk(done == m_done, "R8", "done", done, m_done);
    if (rewind) rew_seen++;
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic load(input int n);
    iter_count = ITER_W'(n);
    iter_load = 1'b1;
    step();
    iter_load = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; run_en = 1'b0; gap_en = 1'b0; rate_en = 1'b0;
    gap_cycles = '0; rate_inc = '0; iter_count = '0; iter_load = 1'b0;
    drive_src();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
    chk(rewind == 1'b0, "R10", "rewind after reset", rewind, 0);
    chk(done == 1'b0, "R10", "done after reset", done, 0);
    @(negedge clk);
    // R8: count zero after reset blocks sending even with run on
    run_en = 1'b1;
    run(5);
    // R3/R5: two passes back to back, then done
    rew_seen = 0;
    load(2);
    run(30);
    chk(rew_seen == 2, "R7", "rewind pulses for 2 passes", rew_seen, 2);
    chk(done == 1'b1, "R8", "done after passes", done, 1);
    // R2: spacing of 3 cycles
    gap_en = 1'b1; gap_cycles = 16'd3;
    load(3);
    run(80);
    // R4: credit pacing
    gap_en = 1'b0; rate_en = 1'b1; rate_inc = 8'd2;
    load(2);
    run(200);
    // combined with downstream stalls and source bubbles
    gap_en = 1'b1; gap_cycles = 16'd2; rate_inc = 8'd5;
    rdy_pat = 1'b1; bub = 1'b1;
    load(5);
    run(150);
    // R6: stop mid-stream, then resume
    rate_en = 1'b0; gap_en = 1'b0; rdy_pat = 1'b0; bub = 1'b0;
    load(20);
    run(2);
    run_en = 1'b0;
    run(20);
    run_en = 1'b1;
    run(30);
    // R7: reload while running overrides the decrement
    load(1);
    run(40);
    chk(done == 1'b1, "R8", "done after reload of one pass", done, 1);
    // R4: saturation at the cap with nothing to send
    rate_en = 1'b1; rate_inc = 8'd200;
    run(20);
    load(1);
    run(20);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule